// File: doc/BRIEF.md
# Quiz Buzzer Controller

This block referees a four-contestant quiz round. The host presses start and the block counts down from nine to zero, one step per second. Answering only opens once the count reaches zero. The first contestant to press after that wins: the winner's lamp stays lit, the buzzer sounds, and every other press is ignored until the next reset.

A contestant who presses while the countdown is still running commits a false start. The countdown freezes at its current value. The offender's lamp and the buzzer then pulse together at the half-second rate until reset.

Timing comes from a built-in divider that produces one-cycle enable pulses at 2 Hz and 1 Hz from the system clock. No derived clocks are used. Every button input is active low, passes through a two-flop synchroniser, and acts only on its falling edge. The outputs are four active-low lamps, an active-low buzzer, the countdown value and the index of the active contestant.

Top module: `quiz_buzzer`

## Requirements
- R1: After reset, all lamps are off (`led_n` = 4'b1111), the buzzer is off (`buzz_n` = 1), `count` shows 9 and `who` is 0 (no contestant).
- R2: A falling edge on `start_n` in the idle state begins the countdown. `count` steps 9, 8, ..., 0, and consecutive steps are exactly 2*HALF_CYCLES clock cycles apart.
- R3: A contestant falling edge while `count` is above 0 is a false start. `who` becomes that contestant's number (bit 0 of `press_n` is contestant 1, bit 3 is contestant 4) and `count` stays frozen.
- R4: During a false start, the offender's lamp and the buzzer are on together on entry. Both then toggle every HALF_CYCLES cycles, and all other lamps stay off.
- R5: A contestant falling edge once `count` is 0 registers a winner. `who` gives the contestant's number, that contestant's lamp stays on steadily and the buzzer sounds continuously.
- R6: When several contestants' edges arrive in the same cycle, the lowest-numbered contestant is chosen. This applies both to winners and to false starts.
- R7: After a winner or a false start is registered, further contestant presses leave `who`, the lamps and `count` unchanged until reset.
- R8: Start is acted on only in the idle state. A start press during the countdown or after a winner changes neither the countdown sequence nor the result.
- R9: Buttons act only on a new falling edge. A press made in the idle state is ignored, and a button held low since before the start produces neither a false start nor a win.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_n | input | 1 | Host start button, active low |
| press_n | input | PLAYERS (4) | Contestant buttons, active low; bit 0 is contestant 1 |
| led_n | output | PLAYERS (4) | Contestant lamps, active low |
| buzz_n | output | 1 | Buzzer, active low |
| count | output | CW (4) | Current countdown value |
| who | output | IW (3) | Active contestant number, 0 for none |

## Verification
The assertions rely on a few assumptions about the inputs. Reset is asserted before the first edge, and HALF_CYCLES is at least 2, so that fast ticks can never fall on adjacent cycles. Buttons are treated as slow level signals that the synchroniser turns into single-cycle edge pulses. The stimulus changes inputs only at falling clock edges and holds each press low for three cycles. Presses meant to be simultaneous are driven in the same cycle, and each button is released before it is pressed again, so every press yields exactly one edge.

// File: rtl/quiz_pkg.sv
package quiz_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_COUNT = 3'd1,
        ST_OPEN  = 3'd2,
        ST_WON   = 3'd3,
        ST_FOUL  = 3'd4
    } quiz_state_e;

endpackage

// File: rtl/quiz_tick_gen.sv
module quiz_tick_gen #(
    parameter int unsigned HALF_CYCLES = 62_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick_fast,
    output logic tick_slow
);
    localparam int unsigned CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          phase;
    } tick_t;

    tick_t tick_d, tick_q;

    assign tick_fast = (tick_q.cnt == LAST);
    assign tick_slow = tick_fast && tick_q.phase;

    always_comb begin
        tick_d = tick_q;
        if (clear) begin
            tick_d.cnt   = '0;
            tick_d.phase = 1'b0;
        end else if (tick_fast) begin
            tick_d.cnt   = '0;
            tick_d.phase = ~tick_q.phase;
        end else begin
            tick_d.cnt = tick_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_d;
    end

    // Fast ticks are isolated pulses, giving the blink its half period
    assert_fast_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_fast |=> !tick_fast);

    // A slow tick is always followed by a gap before the next slow tick
    assert_slow_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_slow |=> !tick_slow);

endmodule

// File: rtl/quiz_btn_sync.sv
module quiz_btn_sync #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_n,
    output logic [N-1:0] fall
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] sync;
        logic [N-1:0] last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.meta = raw_n;
        sync_d.sync = sync_q.meta;
        sync_d.last = sync_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign fall = sync_q.last & ~sync_q.sync;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // Each press yields a single-cycle edge pulse
        assert_edge_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
            fall[i] |=> !fall[i]);
    end

endmodule

// File: rtl/quiz_ctrl.sv
module quiz_ctrl
    import quiz_pkg::*;
#(
    parameter int unsigned PLAYERS    = 4,
    parameter int unsigned COUNT_FROM = 9,
    localparam int unsigned CW = $clog2(COUNT_FROM + 1),
    localparam int unsigned IW = $clog2(PLAYERS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_fall,
    input  logic [PLAYERS-1:0] press_fall,
    input  logic               tick_fast,
    input  logic               tick_slow,
    output logic               tick_clear,
    output logic [PLAYERS-1:0] led_n,
    output logic               buzz_n,
    output logic [CW-1:0]      count,
    output logic [IW-1:0]      who
);
    typedef struct packed {
        quiz_state_e   state;
        logic [CW-1:0] count;
        logic [IW-1:0] who;
        logic          blink;
    } ctrl_t;

    localparam ctrl_t RESET_VAL = '{state: ST_IDLE, count: CW'(COUNT_FROM),
                                   who: '0, blink: 1'b0};

    ctrl_t ctrl_d, ctrl_q;
    logic          hit;
    logic [IW-1:0] first_idx;
    logic          lit;

    // Lowest-numbered contestant wins when edges coincide
    always_comb begin
        hit       = 1'b0;
        first_idx = '0;
        for (int i = PLAYERS - 1; i >= 0; i--) begin
            if (press_fall[i]) begin
                hit       = 1'b1;
                first_idx = IW'(i + 1);
            end
        end
    end

    always_comb begin
        ctrl_d     = ctrl_q;
        tick_clear = 1'b0;
        case (ctrl_q.state)
            ST_IDLE: begin
                if (start_fall) begin
                    ctrl_d.state = ST_COUNT;
                    ctrl_d.count = CW'(COUNT_FROM);
                    tick_clear   = 1'b1;
                end
            end
            ST_COUNT: begin
                if (hit) begin
                    ctrl_d.state = ST_FOUL;
                    ctrl_d.who   = first_idx;
                    ctrl_d.blink = 1'b1;
                    tick_clear   = 1'b1;
                end else if (tick_slow) begin
                    ctrl_d.count = ctrl_q.count - CW'(1);
                    if (ctrl_q.count == CW'(1)) ctrl_d.state = ST_OPEN;
                end
            end
            ST_OPEN: begin
                if (hit) begin
                    ctrl_d.state = ST_WON;
                    ctrl_d.who   = first_idx;
                end
            end
            ST_WON: begin
                ctrl_d = ctrl_q;
            end
            ST_FOUL: begin
                if (tick_fast) ctrl_d.blink = ~ctrl_q.blink;
            end
            default: ctrl_d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= RESET_VAL;
        else        ctrl_q <= ctrl_d;
    end

    assign lit    = (ctrl_q.state == ST_WON) || (ctrl_q.state == ST_FOUL && ctrl_q.blink);
    assign buzz_n = ~lit;
    assign count  = ctrl_q.count;
    assign who    = ctrl_q.who;

    always_comb begin
        for (int i = 0; i < PLAYERS; i++) begin
            led_n[i] = ~(lit && (ctrl_q.who == IW'(i + 1)));
        end
    end

    logic past_ok_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_IDLE) |-> (who == '0 && led_n == '1 && buzz_n));

    assert_count_nonrising_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q |=> (count <= $past(count)));

    assert_open_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_OPEN) |-> (count == '0));

    assert_foul_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_FOUL) |=> ($stable(count) && $stable(who)
                                       && ctrl_q.state == ST_FOUL));

    assert_buzz_follows_lamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        buzz_n == (&led_n));

    assert_single_lamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~led_n) <= 1);

    assert_won_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_WON) |=> (ctrl_q.state == ST_WON && $stable(who)
                                      && $stable(led_n) && !buzz_n));

endmodule

// File: rtl/quiz_buzzer.sv
module quiz_buzzer #(
    parameter int unsigned HALF_CYCLES = 62_500_000,
    parameter int unsigned PLAYERS    = 4,
    parameter int unsigned COUNT_FROM = 9,
    localparam int unsigned CW = $clog2(COUNT_FROM + 1),
    localparam int unsigned IW = $clog2(PLAYERS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_n,
    input  logic [PLAYERS-1:0] press_n,
    output logic [PLAYERS-1:0] led_n,
    output logic               buzz_n,
    output logic [CW-1:0]      count,
    output logic [IW-1:0]      who
);
    logic [PLAYERS:0] fall;
    logic             tick_fast;
    logic             tick_slow;
    logic             tick_clear;

    quiz_btn_sync #(.N(PLAYERS + 1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_n ({start_n, press_n}),
        .fall  (fall)
    );

    quiz_tick_gen #(.HALF_CYCLES(HALF_CYCLES)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (tick_clear),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow)
    );

    quiz_ctrl #(.PLAYERS(PLAYERS), .COUNT_FROM(COUNT_FROM)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_fall (fall[PLAYERS]),
        .press_fall (fall[PLAYERS-1:0]),
        .tick_fast  (tick_fast),
        .tick_slow  (tick_slow),
        .tick_clear (tick_clear),
        .led_n      (led_n),
        .buzz_n     (buzz_n),
        .count      (count),
        .who        (who)
    );

endmodule

// File: tb/quiz_buzzer_test.sv
module quiz_buzzer_test;
    localparam int HALF = 4;
    localparam int SLOW = 2 * HALF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_n = 1'b1;
    logic [3:0] press_n = 4'hF;
    logic [3:0] led_n;
    logic       buzz_n;
    logic [3:0] count;
    logic [2:0] who;

    int n_checks = 0;
    int n_fail = 0;
    int exp_q[$];

    quiz_buzzer #(.HALF_CYCLES(HALF), .PLAYERS(4), .COUNT_FROM(9)) uut (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .press_n(press_n),
        .led_n(led_n), .buzz_n(buzz_n), .count(count), .who(who)
    );

    always #4 clk = ~clk;

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start_n = 1'b1; press_n = 4'hF;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
    endtask

    task automatic tap_start();
        start_n = 1'b0; cyc(3); start_n = 1'b1;
    endtask

    task automatic tap(logic [3:0] mask);
        press_n = ~mask; cyc(3); press_n = 4'hF;
    endtask

    // Driver side of the scoreboard: expected countdown values
    task automatic expect_down(int last);
        for (int v = 8; v >= last; v--) exp_q.push_back(v);
    endtask

    task automatic wait_count(int v);
        while (count != 4'(v)) @(negedge clk);
    endtask

    // Monitor side: pops an expectation on every count change
    int prev_cnt = 9;
    int gap = 0;
    bit gap_ok = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_cnt = count; gap = 0; gap_ok = 1'b0;
        end else begin
            gap++;
            if (int'(count) != prev_cnt) begin
                if (exp_q.size() == 0) check("R2 unexpected count change", count, prev_cnt);
                else check("R2 countdown value", count, exp_q.pop_front());
                if (gap_ok) check("R2 step spacing", gap, SLOW);
                gap_ok = 1'b1; gap = 0; prev_cnt = count;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int runs, bad, mism, len;
        logic prev;

        do_reset();
        check("R1 led_n after reset", led_n, 4'hF);
        check("R1 buzz_n after reset", buzz_n, 1);
        check("R1 count after reset", count, 9);
        check("R1 who after reset", who, 0);

        // Normal round, start retapped mid-countdown, contestant 3 wins
        expect_down(0);
        tap_start();
        wait_count(5);
        tap_start();                       // R8: ignored during countdown
        wait_count(0);
        cyc(2);
        check("R2 queue drained", exp_q.size(), 0);
        check("R2 final count", count, 0);
        tap(4'b0100);
        cyc(3);
        check("R5 winner index", who, 3);
        check("R5 winner lamp", led_n, 4'b1011);
        check("R5 buzzer on", buzz_n, 0);
        cyc(20);
        check("R5 lamp steady", led_n, 4'b1011);
        check("R5 buzzer steady", buzz_n, 0);
        tap(4'b1000);
        cyc(4);
        check("R7 late press ignored who", who, 3);
        check("R7 late press ignored lamp", led_n, 4'b1011);
        tap_start();
        cyc(20);
        check("R8 start after win who", who, 3);
        check("R8 start after win count", count, 0);

        // False start by contestants 2 and 4 together at count 6
        do_reset();
        expect_down(6);
        tap_start();
        wait_count(6);
        press_n = ~4'b1010;
        while (who == 3'd0) @(negedge clk);
        press_n = 4'hF;
        check("R6 R3 offender index", who, 2);
        check("R4 alarm on at entry", buzz_n, 0);
        check("R4 offender lamp on at entry", led_n, 4'b1101);
        runs = 0; bad = 0; mism = 0; len = 1; prev = buzz_n;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (buzz_n != prev) begin
                runs++;
                if (len != HALF) bad++;
                len = 1; prev = buzz_n;
            end else len++;
            if (led_n !== {2'b11, buzz_n, 1'b1}) mism++;
        end
        check("R4 toggle count", int'(runs >= 8), 1);
        check("R4 toggle period", bad, 0);
        check("R4 lamp matches buzzer", mism, 0);
        check("R3 count frozen", count, 6);
        check("R3 no further steps", exp_q.size(), 0);
        tap(4'b0001);
        cyc(4);
        check("R7 press after foul ignored", who, 2);
        check("R7 count after foul", count, 6);

        // All four press together once open
        do_reset();
        expect_down(0);
        tap_start();
        wait_count(0);
        cyc(2);
        tap(4'b1111);
        cyc(3);
        check("R6 tie goes to contestant 1", who, 1);
        check("R6 tie lamp", led_n, 4'b1110);

        // Contestant 1 held low from idle through the countdown
        do_reset();
        press_n = 4'b1110;
        cyc(5);
        check("R9 idle press ignored", who, 0);
        expect_down(0);
        tap_start();
        wait_count(0);
        cyc(10);
        check("R9 held button no result", who, 0);
        check("R9 held button lamps off", led_n, 4'hF);
        check("R9 held button buzzer off", buzz_n, 1);
        press_n = 4'hF;
        cyc(2);
        tap(4'b0010);
        cyc(3);
        check("R9 new edge wins", who, 2);
        check("R2 queue drained at end", exp_q.size(), 0);

        report();
    end

endmodule